// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block shifts a destination operand left or right by a count. The bit positions it empties are refilled from a second source register, so two registers together act as one wide funnel. This lets software build shifts of 64 bits or more out of word-sized steps. Operands are 16 or 32 bits wide. The source register is only read. Its value never reaches any output except through the fill bits.

An operation is presented with `in_valid`, and its results appear registered one clock later under `out_valid`. The results are the shifted value, the carry (the last bit shifted out of the destination), and the sign, zero and parity flags of the result. The count is reduced to its low five bits. A reduced count of zero leaves the flags exactly as they were. A reduced count larger than the operand width raises an `undefined` indicator instead of producing a result.

Top module: `dfunnel_shift`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to 0 on the following cycle.
- R2: The effective amount is `count[4:0]`, so bits 7..5 of the count have no effect (0x24 acts as 4, 0x20 acts as 0).
- R3: An effective amount of 0 returns the destination (zero-extended in 16-bit mode) as the result, clears `undefined`, and keeps `carry`, `sign`, `zero` and `parity` at their previous values.
- R4: A left shift by n returns the upper operand-width bits of {destination, source} shifted left by n, so the low n bits are source bits from its most significant end downward.
- R5: A right shift by n returns the lower operand-width bits of {source, destination} shifted right by n, so the top n bits are the low n source bits.
- R6: `carry` is destination bit (width - n) for a left shift and destination bit (n - 1) for a right shift.
- R7: `sign` is result bit (width - 1), `zero` is 1 when the result is all zeros, and `parity` is 1 when the low 8 result bits hold an even number of ones.
- R8: With `wide` = 0 only bits 15..0 of destination and source take part, result bits 31..16 are 0, and an amount of exactly 16 is defined (result equals the low source half).
- R9: With `wide` = 0 and an amount of 17 to 31, `undefined` is 1, the result is 0 and the four flags keep their previous values; with `wide` = 1 `undefined` is never set.
- R10: `out_valid` follows `in_valid` by one clock, and all result and flag outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| dst | input | 32 | Destination operand |
| src | input | 32 | Fill source operand |
| count | input | 8 | Raw shift count |
| wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| dir_right | input | 1 | 1 = shift right, 0 = shift left |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Shifted value |
| carry | output | 1 | Last bit shifted out of the destination |
| sign | output | 1 | Top bit of the result at the operand width |
| zero | output | 1 | Result equals zero |
| parity | output | 1 | Even number of ones in the low result byte |
| undefined | output | 1 | Amount exceeded the operand width |

## Verification
Distinct, dense destination and source patterns show whether the fill bits come from the correct end of the source and in the correct order, which separates R4 from R5. Counts of 1, the width minus one, exactly 16 in narrow mode, and 17 and 31 in narrow mode probe the edges between defined shifts, the full-width swap and the undefined range. Counts whose upper three bits are set, together with a zero amount issued right after a shift that set the flags, tell modulo reduction apart from the no-op path that holds the flags. Many random operations in both widths and directions then cover the carry index arithmetic across all amounts.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic {
    SHIFT_LEFT  = 1'b0,
    SHIFT_RIGHT = 1'b1
  } shdir_e;

  typedef struct packed {
    logic carry;
    logic sign;
    logic zero;
    logic parity;
  } fsh_flags_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/fsh_amount.sv
module fsh_amount #(
  parameter int CNT_W    = 8,
  parameter int AMT_W    = 5,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             wide_i,
  output logic [AMT_W-1:0] amt_o,
  output logic             noop_o,
  output logic             undef_o
);
  localparam int LIMIT_WIDE   = WIDE_W;
  localparam int LIMIT_NARROW = NARROW_W;

  int amt_int;

  always_comb begin
    amt_o   = count_i[AMT_W-1:0];
    amt_int = int'(amt_o);
    noop_o  = (amt_o == '0);
    if (wide_i) undef_o = (amt_int > LIMIT_WIDE);
    else        undef_o = (amt_int > LIMIT_NARROW);
  end
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
  parameter int W     = 32,
  parameter int AMT_W = 5,
  parameter int OUT_W = 32
) (
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             right_i,
  output logic [OUT_W-1:0] res_o,
  output logic             carry_o
);
  localparam int CAT_W = 2 * W + 1;

  logic [CAT_W-1:0] cat_left;
  logic [CAT_W-1:0] cat_right;
  logic [W-1:0]     res_w;

  always_comb begin
    // left: {guard, dst, src}; guard position catches dst[W-amt]
    cat_left  = {1'b0, dst_i, src_i} << amt_i;
    // right: {src, dst, guard}; guard position catches dst[amt-1]
    cat_right = {src_i, dst_i, 1'b0} >> amt_i;
    if (right_i) begin
      res_w   = cat_right[W:1];
      carry_o = cat_right[0];
    end else begin
      res_w   = cat_left[2*W-1:W];
      carry_o = cat_left[2*W];
    end
    res_o = OUT_W'(res_w);
  end
endmodule

// File: rtl/fsh_flagcalc.sv
module fsh_flagcalc #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         sign_o,
  output logic         zero_o,
  output logic         parity_o
);
  always_comb begin
    sign_o   = res_i[W-1];
    zero_o   = (res_i == '0);
    parity_o = fsh_pkg::even_ones8(res_i[7:0]);
  end
endmodule

// File: rtl/dfunnel_shift.sv
module dfunnel_shift #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int CNT_W    = 8,
  parameter int AMT_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  count,
  input  logic              wide,
  input  logic              dir_right,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              sign,
  output logic              zero,
  output logic              parity,
  output logic              undefined
);
  import fsh_pkg::*;

  localparam int NSIZES = 2;

  logic [AMT_W-1:0]  amt;
  logic              noop;
  logic              undef;
  logic [DATA_W-1:0] size_res [NSIZES];
  fsh_flags_t        size_flg [NSIZES];
  logic [DATA_W-1:0] sel_res;
  fsh_flags_t        sel_flg;
  logic [DATA_W-1:0] pass_res;
  shdir_e            dir;

  assign dir = dir_right ? SHIFT_RIGHT : SHIFT_LEFT;

  fsh_amount #(
    .CNT_W(CNT_W), .AMT_W(AMT_W), .WIDE_W(DATA_W), .NARROW_W(NARROW_W)
  ) u_amount (
    .count_i(count), .wide_i(wide),
    .amt_o(amt), .noop_o(noop), .undef_o(undef)
  );

  // index 0: narrow operands, index 1: full-width operands
  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    localparam int W = (g == 0) ? NARROW_W : DATA_W;
    logic [DATA_W-1:0] res_full;
    logic              cy;
    logic              sg, zr, pr;

    fsh_funnel #(.W(W), .AMT_W(AMT_W), .OUT_W(DATA_W)) u_funnel (
      .dst_i(dst[W-1:0]), .src_i(src[W-1:0]), .amt_i(amt),
      .right_i(dir == SHIFT_RIGHT), .res_o(res_full), .carry_o(cy)
    );

    fsh_flagcalc #(.W(W)) u_flags (
      .res_i(res_full[W-1:0]), .sign_o(sg), .zero_o(zr), .parity_o(pr)
    );

    assign size_res[g] = res_full;
    assign size_flg[g] = '{carry: cy, sign: sg, zero: zr, parity: pr};
  end

  always_comb begin
    sel_res  = wide ? size_res[1] : size_res[0];
    sel_flg  = wide ? size_flg[1] : size_flg[0];
    pass_res = wide ? dst : DATA_W'(dst[NARROW_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= 1'b0;
      sign      <= 1'b0;
      zero      <= 1'b0;
      parity    <= 1'b0;
      undefined <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (noop) begin
          result    <= pass_res;
          undefined <= 1'b0;
        end else if (undef) begin
          result    <= '0;
          undefined <= 1'b1;
        end else begin
          result    <= sel_res;
          undefined <= 1'b0;
          carry     <= sel_flg.carry;
          sign      <= sel_flg.sign;
          zero      <= sel_flg.zero;
          parity    <= sel_flg.parity;
        end
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(carry)));

  // R3
  noop_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count[AMT_W-1:0] == '0) |=>
      ($stable(carry) && $stable(sign) && $stable(zero) && $stable(parity) && !undefined));

  // R9
  narrow_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide && int'(count[AMT_W-1:0]) > NARROW_W) |=>
      (undefined && result == '0 && $stable(carry)));

  // R9
  wide_defined_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide) |=> !undefined);

  // R8
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide) |=> (result[DATA_W-1:NARROW_W] == '0));
endmodule

// File: tb/sim_dfunnel_shift.sv
module sim_dfunnel_shift;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] dst = '0;
  logic [31:0] src = '0;
  logic [7:0]  count = '0;
  logic        wide = 1'b1;
  logic        dir_right = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry, sign, zero, parity, undefined;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0] res;
    logic        c;
    logic        s;
    logic        z;
    logic        p;
    logic        u;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_exp;
  logic  m_c = 0, m_s = 0, m_z = 0, m_p = 0;

  always #5 clk = ~clk;

  dfunnel_shift u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dst(dst), .src(src),
    .count(count), .wide(wide), .dir_right(dir_right),
    .out_valid(out_valid), .result(result), .carry(carry), .sign(sign),
    .zero(zero), .parity(parity), .undefined(undefined)
  );

  // bit-serial reference, one position per step
  function automatic exp_t model(input logic [31:0] d, input logic [31:0] s,
                                 input logic [7:0] cnt, input logic wd,
                                 input logic rt);
    exp_t        e;
    logic [4:0]  a;
    int          w;
    logic [63:0] f;
    logic        c;
    a = cnt[4:0];
    w = wd ? 32 : 16;
    e = '0;
    e.c = m_c; e.s = m_s; e.z = m_z; e.p = m_p;
    c = 1'b0;
    if (a == 0) begin
      e.res = wd ? d : {16'b0, d[15:0]};
    end else if (int'(a) > w) begin
      e.res = '0;
      e.u   = 1'b1;
    end else begin
      if (!rt) begin
        f = wd ? {d, s} : {32'b0, d[15:0], s[15:0]};
        for (int k = 0; k < int'(a); k++) begin
          c = f[2*w-1];
          f = f << 1;
        end
        e.res = wd ? f[63:32] : {16'b0, f[31:16]};
      end else begin
        f = wd ? {s, d} : {32'b0, s[15:0], d[15:0]};
        for (int k = 0; k < int'(a); k++) begin
          c = f[0];
          f = f >> 1;
        end
        e.res = wd ? f[31:0] : {16'b0, f[15:0]};
      end
      e.c = c;
      e.s = e.res[w-1];
      e.z = (e.res == 0);
      e.p = ~(^e.res[7:0]);
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] d, input logic [31:0] s,
                       input logic [7:0] cnt, input logic wd, input logic rt,
                       input string tag);
    exp_t e;
    e = model(d, s, cnt, wd, rt);
    m_c = e.c; m_s = e.s; m_z = e.z; m_p = e.p;
    last_exp = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    dst = d; src = s; count = cnt; wide = wd; dir_right = rt;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  function automatic void compare(input exp_t e, input string tag);
    exp_t a;
    a = '{res: result, c: carry, s: sign, z: zero, p: parity, u: undefined};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b s=%b z=%b p=%b u=%b, expected res=%h c=%b s=%b z=%b p=%b u=%b",
               tag, a.res, a.c, a.s, a.z, a.p, a.u, e.res, e.c, e.s, e.z, e.p, e.u);
    end
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: out_valid=1 with nothing outstanding, expected 0");
      end else begin
        compare(exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic idle_check(input int n);
    in_valid = 1'b0;
    dst = 32'hDEAD_BEEF; src = 32'h1234_5678; count = 8'd7;
    repeat (n) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: out_valid=%b, expected 0", out_valid);
    end
    compare(last_exp, "R10 hold while idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if ({out_valid, result, carry, sign, zero, parity, undefined} !== '0) begin
      errors++;
      $display("FAIL R1: outputs=%h, expected 0",
               {out_valid, result, carry, sign, zero, parity, undefined});
    end
    last_exp = '0;

    drive(32'h8123_4567, 32'hF0E1_D2C3, 8'd4,  1, 0, "R4 left32 by 4");
    drive(32'h8123_4567, 32'hF0E1_D2C3, 8'd8,  1, 1, "R5 right32 by 8");
    drive(32'h4000_0001, 32'h8000_0000, 8'd1,  1, 0, "R6 left32 by 1 carry");
    drive(32'h0000_0003, 32'h0000_0000, 8'd1,  1, 1, "R6 right32 by 1 carry");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 8'd31, 1, 0, "R4 left32 by 31");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 8'd31, 1, 1, "R5 right32 by 31");
    drive(32'h0,         32'h0,         8'd3,  1, 0, "R7 zero result");
    drive(32'h0000_0081, 32'h0,         8'd0,  1, 0, "R3 noop holds flags");
    drive(32'h0000_00F0, 32'hFFFF_FFFF, 8'h24, 1, 0, "R2 count 0x24 acts as 4");
    drive(32'h1357_9BDF, 32'h2468_ACE0, 8'h20, 1, 1, "R2 count 0x20 acts as 0");
    drive(32'hFFFF_9234, 32'hEEEE_ABCD, 8'd5,  0, 0, "R8 narrow left 5");
    drive(32'hFFFF_9234, 32'hEEEE_ABCD, 8'd5,  0, 1, "R8 narrow right 5");
    drive(32'h1111_8001, 32'h2222_5A5A, 8'd16, 0, 0, "R8 narrow left 16");
    drive(32'h1111_8001, 32'h2222_5A5A, 8'd16, 0, 1, "R8 narrow right 16");
    drive(32'h0000_8001, 32'h0000_FFFF, 8'd17, 0, 0, "R9 narrow 17 undefined");
    drive(32'h0000_8001, 32'h0000_FFFF, 8'd31, 0, 1, "R9 narrow 31 undefined");
    drive(32'hFFFF_0F0F, 32'h0,         8'd0,  0, 1, "R3 narrow noop");
    drive(32'h0000_00FF, 32'h0,         8'd8,  1, 1, "R7 parity odd/even");
    idle_check(3);

    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 8'($urandom), 1'($urandom), 1'($urandom),
            "R4/R5/R6/R7 random");
    end
    idle_check(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule